// File: doc/BRIEF.md
# I2C Transfer Byte Queues with Threshold Requests

This block sits between a host register interface and the bus engine of an I2C master. It holds two byte queues: one toward the bus for bytes being sent, and one from the bus for bytes captured during a read. A 16-bit configuration word sets one threshold for each queue, can flush either queue and can enable a DMA request line for each direction. A 16-bit status word reports how many bytes each queue holds and how deep the queues are.

Before a transfer, the controller loads its direction and byte length. The block then tells the host when a threshold's worth of work is ready. For the tail of a transfer that is shorter than the threshold, it raises a drain request instead. The host then reads the status counts to learn how many bytes to move. The block also reports bus-side misuse: a capture into a full receive queue, and a fetch from an empty transmit queue while the transfer still has bytes to send.

Host-side data moves over valid/ready streams. For sending, `host_tx_ready` drops while the transmit queue is full, and a byte offered then is not taken. For receiving, `host_rx_valid` is high while the receive queue holds a byte, and `host_rx_ready` pops it. The bus engine cannot stall the wire, so its side uses single-cycle strobes. It may check `eng_tx_avail` and `eng_rx_room` first, but it is not held back by them.

Top module: `i2cq_top`

## Requirements
- R1: After reset both queues are empty, `stat_rdata` reads 16'h4000 (size code 1 in bits 15:14 for a depth of 8<<1 = 16), `cfg_rdata` reads 0, all request and event outputs are low, `host_tx_ready` is 1 and `host_rx_valid` is 0.
- R2: Each queue delivers bytes in the order they were accepted. `stat_rdata[5:0]` holds the transmit byte count and `stat_rdata[13:8]` holds the receive byte count, both updated one clock after a move.
- R3: `host_tx_ready` is low while the transmit queue holds DEPTH bytes. A byte offered then is not stored, and the count does not change. `host_rx_valid` and `eng_tx_avail` are low while their queue is empty.
- R4: Configuration bits 5:0 hold the transmit threshold minus one and bits 13:8 hold the receive threshold minus one, so a field value f means a threshold T = f+1.
- R5: In a loaded read transfer, `rx_ready_req` is high when the host-side remaining count is at least T and the receive count is at least T.
- R6: In a loaded write transfer, `tx_ready_req` is high when the host-side remaining count is at least T and the free transmit space is at least T. Requests of the other direction stay low.
- R7: When the host-side remaining count r satisfies 0 < r < T, the ready request stays low. The drain request goes high once the receive count (read) or the free transmit space (write) is at least r. Ready and drain are never high together.
- R8: Writing configuration bit 6 empties the transmit queue and writing bit 14 empties the receive queue by the next cycle. The other queue is untouched, the clear beats a push in the same cycle, and both bits read back as 0.
- R9: Configuration bit 7 gates `tx_dma_req` = tx ready or tx drain, and bit 15 gates `rx_dma_req` the same way for the receive direction.
- R10: A bus capture (`eng_rx_push`) while the receive queue is full drops the byte, leaves the queue unchanged and pulses `rx_overrun` for one cycle after the edge.
- R11: A bus fetch (`eng_tx_take`) while the transmit queue is empty, in a write transfer with bus bytes still remaining, pulses `tx_underflow` for one cycle. No pulse occurs in a read transfer or when no bus bytes remain.
- R12: `xfer_load` sets the remaining counts to `xfer_len`, replacing any earlier transfer. The host-side count falls by one per accepted host byte in the transfer's direction and stops at 0. The bus-side count falls per bus byte moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback (clear bits read 0) |
| stat_rdata | output | 16 | Queue counts and size code |
| host_tx_valid | input | 1 | Host offers a byte to send |
| host_tx_ready | output | 1 | Transmit queue can take a byte |
| host_tx_data | input | 8 | Byte to send |
| host_rx_valid | output | 1 | Received byte available |
| host_rx_ready | input | 1 | Host takes the received byte |
| host_rx_data | output | 8 | Oldest received byte |
| eng_tx_take | input | 1 | Bus engine fetches a byte to send |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 8 | Oldest byte to send |
| eng_rx_push | input | 1 | Bus engine delivers a captured byte |
| eng_rx_data | input | 8 | Captured byte |
| eng_rx_room | output | 1 | Receive queue not full |
| xfer_load | input | 1 | Start a transfer |
| xfer_rd | input | 1 | Transfer direction, 1 for read |
| xfer_len | input | LEN_W | Transfer length in bytes |
| tx_ready_req | output | 1 | Transmit threshold request |
| tx_drain_req | output | 1 | Transmit tail request |
| rx_ready_req | output | 1 | Receive threshold request |
| rx_drain_req | output | 1 | Receive tail request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_underflow | output | 1 | Fetch from an empty transmit queue |
| rx_overrun | output | 1 | Capture into a full receive queue |

## Verification
A flush written through the configuration port can land in the same cycle as a byte push into the queue being flushed. The bench drives a receive-queue clear together with `eng_rx_push` and expects a count of zero afterwards. A second collision is a fetch or capture at a queue boundary arriving together with the request logic's own threshold crossing. The threshold sweeps step the fill level past every threshold from 1 to 17 against several transfer lengths. At each step they compare ready, drain and DMA lines with values computed from the remaining count and the fill level.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  // Configuration word layout (bit positions are decoded by the block)
  typedef struct packed {
    logic       rx_dma;
    logic       rx_clr;
    logic [5:0] rx_thr_m1;
    logic       tx_dma;
    logic       tx_clr;
    logic [5:0] tx_thr_m1;
  } cfg_t;

  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok)  rp <= rp + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/i2cq_req.sv
module i2cq_req #(
  parameter int unsigned RW = 8,
  parameter int unsigned VW = 5
) (
  input  logic          active,
  input  logic [6:0]    thr,
  input  logic [RW-1:0] rem,
  input  logic [VW-1:0] level,
  output logic          ready,
  output logic          drain
);
  logic [15:0] t, r, v;
  assign t = 16'(thr);
  assign r = 16'(rem);
  assign v = 16'(level);

  assign ready = active && (r >= t) && (v >= t);
  assign drain = active && (r != '0) && (r < t) && (v >= r);
endmodule

// File: rtl/i2cq_xfer.sv
module i2cq_xfer #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rd,
  input  logic [LEN_W-1:0] len,
  input  logic             host_tx_acc,
  input  logic             host_rx_acc,
  input  logic             bus_tx_acc,
  input  logic             bus_rx_acc,
  output logic             loaded,
  output logic             is_rd,
  output logic [LEN_W-1:0] host_rem,
  output logic [LEN_W-1:0] bus_rem
);
  logic host_dec, bus_dec;
  assign host_dec = is_rd ? host_rx_acc : host_tx_acc;
  assign bus_dec  = is_rd ? bus_rx_acc  : bus_tx_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      is_rd    <= 1'b0;
      host_rem <= '0;
      bus_rem  <= '0;
    end else if (load) begin
      loaded   <= 1'b1;
      is_rd    <= rd;
      host_rem <= len;
      bus_rem  <= len;
    end else begin
      if (host_dec && host_rem != '0) host_rem <= host_rem - LEN_W'(1);
      if (bus_dec && bus_rem != '0)   bus_rem  <= bus_rem - LEN_W'(1);
    end
  end
endmodule

// File: rtl/i2cq_top.sv
module i2cq_top #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic [15:0]      stat_rdata,
  input  logic             host_tx_valid,
  output logic             host_tx_ready,
  input  logic [7:0]       host_tx_data,
  output logic             host_rx_valid,
  input  logic             host_rx_ready,
  output logic [7:0]       host_rx_data,
  input  logic             eng_tx_take,
  output logic             eng_tx_avail,
  output logic [7:0]       eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [7:0]       eng_rx_data,
  output logic             eng_rx_room,
  input  logic             xfer_load,
  input  logic             xfer_rd,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             tx_ready_req,
  output logic             tx_drain_req,
  output logic             rx_ready_req,
  output logic             rx_drain_req,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic             tx_underflow,
  output logic             rx_overrun
);
  import i2cq_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam logic [1:0]  SZ = 2'($clog2(DEPTH) - 3);

  cfg_t            cfg_q, cfg_in;
  logic            tx_clr, rx_clr;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            loaded, is_rd;
  logic [LEN_W-1:0] host_rem, bus_rem;
  logic            host_tx_acc, host_rx_acc, bus_tx_acc;

  // configuration register; flush bits act once and are not stored
  assign cfg_in = cfg_t'(cfg_wdata);
  assign tx_clr = cfg_wr && cfg_in.tx_clr;
  assign rx_clr = cfg_wr && cfg_in.rx_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q        <= cfg_in;
      cfg_q.tx_clr <= 1'b0;
      cfg_q.rx_clr <= 1'b0;
    end
  end
  assign cfg_rdata = cfg_q;

  i2cq_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(host_tx_valid), .din(host_tx_data),
    .pop(eng_tx_take), .dout(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2cq_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(host_rx_ready), .dout(host_rx_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign host_tx_ready = !tx_full;
  assign host_rx_valid = !rx_empty;
  assign eng_tx_avail  = !tx_empty;
  assign eng_rx_room   = !rx_full;

  assign host_tx_acc = host_tx_valid && !tx_full;
  assign host_rx_acc = host_rx_ready && !rx_empty;
  assign bus_tx_acc  = eng_tx_take && !tx_empty;

  i2cq_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .load(xfer_load), .rd(xfer_rd), .len(xfer_len),
    .host_tx_acc(host_tx_acc), .host_rx_acc(host_rx_acc),
    .bus_tx_acc(bus_tx_acc), .bus_rx_acc(eng_rx_push),
    .loaded(loaded), .is_rd(is_rd), .host_rem(host_rem), .bus_rem(bus_rem)
  );

  // per-direction request logic
  logic          act [2];
  logic [6:0]    thr [2];
  logic [CW-1:0] lvl [2];
  logic          rdy [2];
  logic          drn [2];

  assign act[DIR_TX] = loaded && !is_rd;
  assign act[DIR_RX] = loaded && is_rd;
  assign thr[DIR_TX] = {1'b0, cfg_q.tx_thr_m1} + 7'd1;
  assign thr[DIR_RX] = {1'b0, cfg_q.rx_thr_m1} + 7'd1;
  assign lvl[DIR_TX] = CW'(DEPTH) - tx_cnt;
  assign lvl[DIR_RX] = rx_cnt;

  for (genvar d = 0; d < 2; d++) begin : g_req
    i2cq_req #(.RW(LEN_W), .VW(CW)) u_req (
      .active(act[d]), .thr(thr[d]), .rem(host_rem), .level(lvl[d]),
      .ready(rdy[d]), .drain(drn[d])
    );
  end

  assign tx_ready_req = rdy[DIR_TX];
  assign tx_drain_req = drn[DIR_TX];
  assign rx_ready_req = rdy[DIR_RX];
  assign rx_drain_req = drn[DIR_RX];
  assign tx_dma_req   = cfg_q.tx_dma && (rdy[DIR_TX] || drn[DIR_TX]);
  assign rx_dma_req   = cfg_q.rx_dma && (rdy[DIR_RX] || drn[DIR_RX]);

  // bus-side misuse events, one-cycle pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_underflow <= 1'b0;
      rx_overrun   <= 1'b0;
    end else begin
      tx_underflow <= eng_tx_take && tx_empty && loaded && !is_rd && (bus_rem != '0);
      rx_overrun   <= eng_rx_push && rx_full;
    end
  end

  assign stat_rdata = {SZ, 6'(rx_cnt), 2'b00, 6'(tx_cnt)};
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_rdata,
  input logic [15:0] stat_rdata,
  input logic        host_tx_valid,
  input logic        host_tx_ready,
  input logic        eng_tx_take,
  input logic        eng_rx_push,
  input logic        tx_ready_req,
  input logic        tx_drain_req,
  input logic        rx_ready_req,
  input logic        rx_drain_req,
  input logic        tx_dma_req,
  input logic        tx_underflow,
  input logic        rx_overrun
);
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[5:0] <= 6'(DEPTH)); // R3
  AST_TX_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_valid && !host_tx_ready && !eng_tx_take && !(cfg_wr && cfg_wdata[6])
    |=> $stable(stat_rdata[5:0])); // R3
  AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready_req && tx_drain_req)); // R7
  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready_req && rx_drain_req)); // R7
  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[6] |=> stat_rdata[5:0] == 6'd0); // R8
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[14] |=> stat_rdata[13:8] == 6'd0); // R8
  AST_FLUSH_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_rdata[6] && !cfg_rdata[14]); // R8
  AST_TX_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (tx_ready_req || tx_drain_req)); // R9
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && stat_rdata[13:8] == 6'(DEPTH) |=> rx_overrun); // R10
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(eng_rx_push)); // R10
  AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |-> $past(eng_tx_take && stat_rdata[5:0] == 6'd0)); // R11
endmodule

bind i2cq_top i2cq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_i2cq_top.sv
`timescale 1ns/1ps
module tb_i2cq_top;
  localparam int DEPTH = 16;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata, stat_rdata;
  logic host_tx_valid = 1'b0, host_tx_ready;
  logic [7:0] host_tx_data = '0;
  logic host_rx_valid, host_rx_ready = 1'b0;
  logic [7:0] host_rx_data;
  logic eng_tx_take = 1'b0, eng_tx_avail;
  logic [7:0] eng_tx_data;
  logic eng_rx_push = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic eng_rx_room;
  logic xfer_load = 1'b0, xfer_rd = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic tx_ready_req, tx_drain_req, rx_ready_req, rx_drain_req;
  logic tx_dma_req, rx_dma_req, tx_underflow, rx_overrun;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2cq_top #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic load(input logic rd, input int len);
    xfer_load = 1'b1; xfer_rd = rd; xfer_len = LEN_W'(len);
    @(negedge clk);
    xfer_load = 1'b0;
  endtask

  task automatic hpush(input logic [7:0] d);
    host_tx_valid = 1'b1; host_tx_data = d;
    @(negedge clk);
    host_tx_valid = 1'b0;
  endtask

  task automatic epush(input logic [7:0] d);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic etake(output logic [7:0] d);
    d = eng_tx_data; eng_tx_take = 1'b1;
    @(negedge clk);
    eng_tx_take = 1'b0;
  endtask

  task automatic hpop(output logic [7:0] d);
    d = host_rx_data; host_rx_ready = 1'b1;
    @(negedge clk);
    host_rx_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int lens [7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 stat", stat_rdata, 16'h4000);
    chk("R1 cfg", cfg_rdata, 16'h0000);
    chk("R1 reqs", {tx_ready_req, tx_drain_req, rx_ready_req, rx_drain_req,
                    tx_dma_req, rx_dma_req, tx_underflow, rx_overrun}, 8'h00);
    chk("R1 tx_ready", host_tx_ready, 1'b1);
    chk("R1 rx_valid", host_rx_valid, 1'b0);

    // R4 config readback: flush bits not stored
    wcfg(16'hFFFF);
    chk("R4 cfg readback", cfg_rdata, 16'hBFBF);

    // R2 ordering on the transmit side
    wcfg(16'h4040);
    load(1'b0, 8);
    for (int i = 0; i < 8; i++) hpush(8'hA0 + 8'(i));
    chk("R2 tx count", stat_rdata[5:0], 6'd8);
    for (int i = 0; i < 8; i++) begin
      etake(b);
      chk("R2 tx order", b, 8'hA0 + 8'(i));
    end
    chk("R2 tx count drained", stat_rdata[5:0], 6'd0);

    // R2 ordering on the receive side
    load(1'b1, 8);
    for (int i = 0; i < 8; i++) epush(8'hC0 + 8'(i));
    chk("R2 rx count", stat_rdata[13:8], 6'd8);
    for (int i = 0; i < 8; i++) begin
      hpop(b);
      chk("R2 rx order", b, 8'hC0 + 8'(i));
    end
    chk("R2 rx empty", host_rx_valid, 1'b0);

    // R3 back-pressure on a full transmit queue
    wcfg(16'h4040);
    load(1'b0, 40);
    for (int i = 0; i < DEPTH; i++) hpush(8'(i + 1));
    chk("R3 ready low when full", host_tx_ready, 1'b0);
    hpush(8'hFF);
    chk("R3 count held", stat_rdata[5:0], 6'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      etake(b);
      chk("R3 stored bytes", b, 8'(i + 1));
    end
    chk("R3 avail low when empty", eng_tx_avail, 1'b0);

    // R10 overrun
    wcfg(16'h4040);
    load(1'b1, 40);
    for (int i = 0; i < DEPTH; i++) epush(8'(i));
    chk("R10 room low", eng_rx_room, 1'b0);
    epush(8'hEE);
    chk("R10 overrun pulse", rx_overrun, 1'b1);
    chk("R10 count held", stat_rdata[13:8], 6'(DEPTH));
    @(negedge clk);
    chk("R10 pulse ends", rx_overrun, 1'b0);
    hpop(b);
    chk("R10 oldest byte kept", b, 8'h00);

    // R11 underflow
    wcfg(16'h4040);
    load(1'b0, 3);
    etake(b);
    chk("R11 underflow pulse", tx_underflow, 1'b1);
    @(negedge clk);
    chk("R11 pulse ends", tx_underflow, 1'b0);
    load(1'b1, 3);
    etake(b);
    chk("R11 no pulse on read", tx_underflow, 1'b0);
    load(1'b0, 0);
    etake(b);
    chk("R11 no pulse at zero remaining", tx_underflow, 1'b0);

    // R8 flush of one queue leaves the other
    wcfg(16'h4040);
    load(1'b0, 20);
    for (int i = 0; i < 5; i++) hpush(8'(i));
    for (int i = 0; i < 3; i++) epush(8'(i));
    wcfg(16'h0040);
    chk("R8 tx flushed", stat_rdata[5:0], 6'd0);
    chk("R8 rx untouched", stat_rdata[13:8], 6'd3);
    chk("R8 flush bit reads 0", cfg_rdata[6], 1'b0);
    cfg_wr = 1'b1; cfg_wdata = 16'h4000; eng_rx_push = 1'b1; eng_rx_data = 8'h55;
    @(negedge clk);
    cfg_wr = 1'b0; eng_rx_push = 1'b0;
    chk("R8 flush beats push", stat_rdata[13:8], 6'd0);

    // R12 reload replaces the remaining count (tx threshold 4)
    wcfg(16'h4043);
    load(1'b0, 5);
    hpush(8'h1); hpush(8'h2);
    chk("R12 tail drain", {tx_ready_req, tx_drain_req}, 2'b01);
    load(1'b0, 10);
    chk("R12 reload ready", {tx_ready_req, tx_drain_req}, 2'b10);

    // R5 R7 R9 receive threshold sweep
    for (int t = 1; t <= 17; t++) begin
      lens = '{0, 1, t - 1, t, t + 1, 16, 20};
      foreach (lens[k]) begin
        int L;
        logic dma;
        L = lens[k];
        dma = (t % 2 == 1);
        wcfg(16'h4040 | 16'((t - 1) << 8) | (dma ? 16'h8000 : 16'h0));
        load(1'b1, L);
        for (int n = 0; n <= DEPTH; n++) begin
          logic er, ed;
          er = (L >= t) && (n >= t);
          ed = (L != 0) && (L < t) && (n >= L);
          chk("R5 rx ready", rx_ready_req, er);
          chk("R7 rx drain", rx_drain_req, ed);
          chk("R9 rx dma", rx_dma_req, dma && (er || ed));
          chk("R6 tx idle in read", {tx_ready_req, tx_drain_req}, 2'b00);
          if (n < DEPTH) epush(8'(n));
        end
      end
    end

    // R6 R7 R9 transmit threshold sweep
    for (int t = 1; t <= 17; t++) begin
      lens = '{0, 1, t - 1, t, t + 1, 16, 20};
      foreach (lens[k]) begin
        int L;
        logic dma;
        L = lens[k];
        dma = (t % 2 == 0);
        wcfg(16'h4040 | 16'(t - 1) | (dma ? 16'h0080 : 16'h0));
        load(1'b0, L);
        for (int n = 0; n <= DEPTH; n++) begin
          int rem, fr;
          logic er, ed;
          rem = (L > n) ? L - n : 0;
          fr = DEPTH - n;
          er = (rem >= t) && (fr >= t);
          ed = (rem != 0) && (rem < t) && (fr >= rem);
          chk("R6 tx ready", tx_ready_req, er);
          chk("R7 tx drain", tx_drain_req, ed);
          chk("R9 tx dma", tx_dma_req, dma && (er || ed));
          chk("R5 rx idle in write", {rx_ready_req, rx_drain_req}, 2'b00);
          if (n < DEPTH) hpush(8'(n));
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule